// File: doc/BRIEF.md
# Bus-cycle DRAM strobe sequencer with refresh

This block sits between an 8-bit processor bus and multiplexed-address DRAM. It watches the processor's active-low memory request, read, write and refresh strobes and produces the active-low row strobe, column strobe, write enable and output enable. It also drives the shared address pins: the row half of the physical address first, then the column half. The physical address is the 16-bit bus address extended upward by the mapper page bits. All minimum strobe widths and precharge gaps are counted in system clocks and set by parameters.

Refresh comes from the processor's refresh cycle, which carries a 7-bit row count. The block widens that count with a small counter that steps each time the 7-bit value wraps, so devices with 256 or 512 refresh rows see every row. A build-time option replaces the row-only refresh with a column-before-row cycle. In that cycle the DRAM uses its internal row counter. A refresh request that arrives during an access waits until the access has finished and the row strobe has met its precharge gap.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: While rst_ni is low, and on release, ras_no, cas_no, we_no and oe_no are all high.
- R2: Every low pulse of ras_no lasts at least T_RAS clocks, even when the bus cycle is one clock long.
- R3: Between two low pulses, ras_no stays high for at least max(T_RP, T_CP) clocks. The column strobe is high throughout that gap.
- R4: Every low pulse of cas_no lasts at least T_CAS clocks.
- R5: For an access, the physical address is {page_i, addr_i}. dram_addr_o shows its low ROW_W bits when ras_no falls and its high ROW_W bits when cas_no falls. cas_no falls at least T_MUX+1 clocks after ras_no.
- R6: we_no is low when cas_no falls for a write cycle (wr_ni low at start) and high for a read cycle. It does not change on the clock where cas_no falls.
- R7: oe_no goes low only during the column phase of a read. It stays high during writes and refreshes.
- R8: An access starts when mreq_ni is low, rfsh_ni is high and rd_ni or wr_ni is low. ras_no stays low until mreq_ni has returned high.
- R9: A refresh request is the clock where mreq_ni and rfsh_ni first become low together. In row-only mode it gives one ras_no pulse with cas_no high and dram_addr_o = {extension, rfsh_addr_i} (zero-filled above).
- R10: The EXT_W-bit extension increments (modulo 2^EXT_W) when a refresh request carries address 0 and the previous request carried 127. Otherwise it holds. It is 0 after reset.
- R11: In column-before-row mode, cas_no falls while ras_no is high, at least T_CSR clocks before ras_no falls. Both strobes rise on the same clock.
- R12: A refresh request raised during an access does not lower ras_no again until the access has ended and the precharge gap of R3 has passed. It is then serviced with the row latched at request time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_ni | input | 1 | Processor memory request, active low |
| rd_ni | input | 1 | Processor read strobe, active low |
| wr_ni | input | 1 | Processor write strobe, active low |
| rfsh_ni | input | 1 | Processor refresh strobe, active low |
| addr_i | input | 16 | Processor address |
| page_i | input | PAGE_W | Mapper page bits, placed above addr_i |
| rfsh_addr_i | input | 7 | Processor refresh row count |
| ras_no | output | 1 | DRAM row strobe, active low |
| cas_no | output | 1 | DRAM column strobe, active low |
| we_no | output | 1 | DRAM write enable, active low |
| oe_no | output | 1 | DRAM output enable, active low |
| dram_addr_o | output | (16+PAGE_W)/2 | Multiplexed row/column address |

## Verification
The bench measures every strobe pulse and gap at the pins. It also uses a one-clock bus cycle, which would expose a sequencer that drops the row strobe as soon as the request ends and so cuts T_RAS short. It sends refresh addresses 127 then 0 several times. A design that steps the extension on the wrong condition, or fails to wrap it, drives the wrong high row bits. A refresh is raised in the middle of a long read. A design without the pending latch either loses that refresh or breaks into the open row. A second instance built for column-before-row refresh is checked for column-strobe lead and for both strobes rising together. A wrong ordering there would make the DRAM run a normal cycle instead of a refresh.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_MUX, ST_COL, ST_RF_ROR, ST_RF_CAS, ST_RF_RAS
  } dram_st_e;

  typedef enum logic [1:0] {SEL_LIVE, SEL_ROW, SEL_COL, SEL_RF} mux_sel_e;
endpackage

// File: rtl/dram_run_cnt.sv
// Counts consecutive clocks with level_i high, saturating.
module dram_run_cnt #(
  parameter int CW      = 4,
  parameter bit SAT_RST = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          level_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_o <= {CW{SAT_RST}};
    else if (!level_i)         cnt_o <= '0;
    else if (cnt_o != '1)      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dram_rfsh_ext.sv
// Widens the 7-bit processor refresh count for deeper refresh sequences.
module dram_rfsh_ext #(
  parameter int ROW_W = 9,
  parameter int EXT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [6:0]       addr_i,
  output logic [ROW_W-1:0] row_o
);
  logic [6:0]       last_q;
  logic [ROW_W-1:0] row_d;

  generate
    if (EXT_W > 0) begin : g_ext
      logic [EXT_W-1:0] ext_q, ext_d;
      assign ext_d = (last_q == 7'h7f && addr_i == 7'h00) ? ext_q + 1'b1 : ext_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     ext_q <= '0;
        else if (load_i) ext_q <= ext_d;
      end
      always_comb begin
        row_d = '0;
        row_d[6:0] = addr_i;
        row_d[7 +: EXT_W] = ext_d;
      end
    end else begin : g_plain
      always_comb begin
        row_d = '0;
        row_d[6:0] = addr_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      row_o  <= '0;
    end else if (load_i) begin
      last_q <= addr_i;
      row_o  <= row_d;
    end
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W = 9
) (
  input  mux_sel_e           sel_i,
  input  logic [ROW_W-1:0]   live_row_i,
  input  logic [2*ROW_W-1:0] phys_q_i,
  input  logic [ROW_W-1:0]   rf_row_i,
  output logic [ROW_W-1:0]   addr_o
);
  always_comb begin
    unique case (sel_i)
      SEL_LIVE: addr_o = live_row_i;
      SEL_ROW:  addr_o = phys_q_i[ROW_W-1:0];
      SEL_COL:  addr_o = phys_q_i[2*ROW_W-1:ROW_W];
      default:  addr_o = rf_row_i;
    endcase
  end
endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int PAGE_W      = 2,
  parameter int EXT_W       = 2,
  parameter int T_RAS       = 4,
  parameter int T_RP        = 3,
  parameter int T_CAS       = 2,
  parameter int T_CP        = 2,
  parameter int T_MUX       = 1,
  parameter int T_CSR       = 1,
  parameter bit CBR_REFRESH = 1'b0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      mreq_ni,
  input  logic                      rd_ni,
  input  logic                      wr_ni,
  input  logic                      rfsh_ni,
  input  logic [15:0]               addr_i,
  input  logic [PAGE_W-1:0]         page_i,
  input  logic [6:0]                rfsh_addr_i,
  output logic                      ras_no,
  output logic                      cas_no,
  output logic                      we_no,
  output logic                      oe_no,
  output logic [(16+PAGE_W)/2-1:0]  dram_addr_o
);
  localparam int PHYS_W = 16 + PAGE_W;
  localparam int ROW_W  = PHYS_W / 2;
  localparam int T_PRE  = (T_RP > T_CP) ? T_RP : T_CP;
  localparam int CW     = $clog2(T_RAS + T_RP + T_CAS + T_CP + T_MUX + T_CSR + 2);
  localparam logic [CW-1:0] RAS_M1 = CW'(T_RAS - 1);
  localparam logic [CW-1:0] CAS_M1 = CW'(T_CAS - 1);
  localparam logic [CW-1:0] PRE_M1 = CW'(T_PRE - 1);
  localparam logic [CW-1:0] CSR_M1 = CW'(T_CSR - 1);
  localparam logic [CW-1:0] MUX_N  = CW'(T_MUX);
  localparam dram_st_e RF_FIRST = CBR_REFRESH ? ST_RF_CAS : ST_RF_ROR;

  dram_st_e           st_q, st_d;
  logic               start_acc, start_rf;
  logic               ras_low, cas_low;
  logic [CW-1:0]      ras_cnt, cas_cnt, hi_cnt;
  logic [PHYS_W-1:0]  phys_live, phys_q;
  logic               op_wr_q;
  logic               rf_req, rf_req_q, rf_edge, pend_q;
  logic [ROW_W-1:0]   rf_row, rf_act_q;
  mux_sel_e           sel;

  assign phys_live = {page_i, addr_i};
  assign rf_req    = ~rfsh_ni & ~mreq_ni;
  assign rf_edge   = rf_req & ~rf_req_q;
  wire   acc_req   = ~mreq_ni & rfsh_ni & (~rd_ni | ~wr_ni);

  assign ras_low = st_q inside {ST_ROW, ST_MUX, ST_COL, ST_RF_ROR, ST_RF_RAS};
  assign cas_low = st_q inside {ST_COL, ST_RF_CAS, ST_RF_RAS};

  dram_run_cnt #(.CW(CW), .SAT_RST(1'b0)) u_ras_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(ras_low),  .cnt_o(ras_cnt));
  dram_run_cnt #(.CW(CW), .SAT_RST(1'b0)) u_cas_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(cas_low),  .cnt_o(cas_cnt));
  dram_run_cnt #(.CW(CW), .SAT_RST(1'b1)) u_ras_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(!ras_low), .cnt_o(hi_cnt));

  dram_rfsh_ext #(.ROW_W(ROW_W), .EXT_W(EXT_W)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rf_edge),
    .addr_i(rfsh_addr_i), .row_o(rf_row));

  always_comb begin
    st_d      = st_q;
    start_acc = 1'b0;
    start_rf  = 1'b0;
    unique case (st_q)
      ST_IDLE:
        if (hi_cnt >= PRE_M1) begin
          if (pend_q) begin
            start_rf = 1'b1;
            st_d     = RF_FIRST;
          end else if (acc_req) begin
            start_acc = 1'b1;
            st_d      = ST_ROW;
          end
        end
      ST_ROW:    st_d = ST_MUX;
      ST_MUX:    if (ras_cnt >= MUX_N) st_d = ST_COL;
      ST_COL:    if (cas_cnt >= CAS_M1 && ras_cnt >= RAS_M1 && mreq_ni) st_d = ST_IDLE;
      ST_RF_ROR: if (ras_cnt >= RAS_M1) st_d = ST_IDLE;
      ST_RF_CAS: if (cas_cnt >= CSR_M1) st_d = ST_RF_RAS;
      ST_RF_RAS: if (ras_cnt >= RAS_M1) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      phys_q   <= '0;
      op_wr_q  <= 1'b0;
      rf_req_q <= 1'b0;
      pend_q   <= 1'b0;
      rf_act_q <= '0;
    end else begin
      st_q     <= st_d;
      rf_req_q <= rf_req;
      if (start_acc) begin
        phys_q  <= phys_live;
        op_wr_q <= ~wr_ni;
      end
      if (start_rf) rf_act_q <= rf_row;
      // a new request outranks the clear so none is lost
      if (rf_edge)       pend_q <= 1'b1;
      else if (start_rf) pend_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE:       sel = pend_q ? SEL_RF : SEL_LIVE;
      ST_ROW:        sel = SEL_ROW;
      ST_MUX, ST_COL: sel = SEL_COL;
      default:       sel = SEL_RF;
    endcase
  end

  dram_addr_mux #(.ROW_W(ROW_W)) u_mux (
    .sel_i(sel), .live_row_i(phys_live[ROW_W-1:0]), .phys_q_i(phys_q),
    .rf_row_i((st_q == ST_IDLE) ? rf_row : rf_act_q), .addr_o(dram_addr_o));

  assign ras_no = ~ras_low;
  assign cas_no = ~cas_low;
  assign we_no  = ~(op_wr_q && (st_q inside {ST_ROW, ST_MUX, ST_COL}));
  assign oe_no  = ~(!op_wr_q && st_q == ST_COL);

  // pin-level run lengths for the timing assertions
  logic [CW-1:0] a_ras_lo, a_ras_hi, a_cas_lo;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_ras_lo <= '0;
      a_ras_hi <= '1;
      a_cas_lo <= '0;
    end else begin
      a_ras_lo <= ras_no  ? '0 : (a_ras_lo == '1 ? a_ras_lo : a_ras_lo + 1'b1);
      a_ras_hi <= !ras_no ? '0 : (a_ras_hi == '1 ? a_ras_hi : a_ras_hi + 1'b1);
      a_cas_lo <= cas_no  ? '0 : (a_cas_lo == '1 ? a_cas_lo : a_cas_lo + 1'b1);
    end
  end

  assert_ras_active_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |-> a_ras_lo >= CW'(T_RAS));
  assert_ras_precharge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> a_ras_hi >= CW'(T_PRE));
  assert_cas_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_no) |-> a_cas_lo >= CW'(T_CAS));
  assert_row_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_no) |-> $stable(dram_addr_o));
  assert_col_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_no && $past(!cas_no)) |-> $stable(dram_addr_o));
  assert_we_settled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_no) |-> $stable(we_no));
  assert_oe_not_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> oe_no);
  assert_rf_ras_with_cas_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CBR_REFRESH && $rose(ras_no)) |-> cas_no);
endmodule

// File: tb/dram_strobe_ctrl_bench.sv
module dram_strobe_ctrl_bench;
  localparam int PAGE_W = 2, ROW_W = 9, EXT_W = 2;
  localparam int T_RAS = 4, T_RP = 3, T_CAS = 2, T_CP = 2, T_MUX = 1, T_CSR = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, mreq_n, rd_n, wr_n, rfsh_n;
  logic [15:0] addr;
  logic [PAGE_W-1:0] page;
  logic [6:0] rf_a;
  logic ras_n, cas_n, we_n, oe_n;
  logic [ROW_W-1:0] d_addr;
  logic c_ras_n, c_cas_n, c_we_n, c_oe_n;
  logic [ROW_W-1:0] c_addr;

  dram_strobe_ctrl #(.PAGE_W(PAGE_W), .EXT_W(EXT_W), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_CAS(T_CAS), .T_CP(T_CP), .T_MUX(T_MUX), .T_CSR(T_CSR), .CBR_REFRESH(1'b0))
  u_dram_strobe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mreq_ni(mreq_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .rfsh_ni(rfsh_n), .addr_i(addr), .page_i(page), .rfsh_addr_i(rf_a),
    .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .oe_no(oe_n), .dram_addr_o(d_addr));

  dram_strobe_ctrl #(.PAGE_W(PAGE_W), .EXT_W(EXT_W), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_CAS(T_CAS), .T_CP(T_CP), .T_MUX(T_MUX), .T_CSR(T_CSR), .CBR_REFRESH(1'b1))
  u_dram_strobe_ctrl_cbr (
    .clk_i(clk), .rst_ni(rst_n), .mreq_ni(mreq_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .rfsh_ni(rfsh_n), .addr_i(addr), .page_i(page), .rfsh_addr_i(rf_a),
    .ras_no(c_ras_n), .cas_no(c_cas_n), .we_no(c_we_n), .oe_no(c_oe_n), .dram_addr_o(c_addr));

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pin monitor, sampled on the falling edge
  int cyc = 0;
  bit p_ras = 1, p_cas = 1, pc_ras = 1, pc_cas = 1;
  int lo_run = 0, hi_run = 100, clo_run = 0;
  int ras_falls = 0, cas_falls = 0, last_lo = 0, last_hi = 0;
  int ras_fall_cyc = 0, ras_fall_addr = 0, cas_fall_addr = 0;
  bit ras_fall_cas = 1, cas_fall_we = 1, oe_seen = 0;
  int c_ras_fall = 0, c_cas_fall = 0, c_ras_rise = 0, c_cas_rise = 0;
  bit c_fall_cas = 1;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        ras_falls++; ras_fall_cyc = cyc; ras_fall_addr = int'(d_addr);
        ras_fall_cas = cas_n; last_hi = hi_run;
        check(hi_run >= T_RP, "R3 ras precharge", hi_run, T_RP);
      end
      if (!p_ras && ras_n) begin
        last_lo = lo_run;
        check(lo_run >= T_RAS, "R2 ras active", lo_run, T_RAS);
      end
      if (p_cas && !cas_n) begin
        cas_falls++; cas_fall_addr = int'(d_addr); cas_fall_we = we_n;
        check(cyc - ras_fall_cyc >= T_MUX + 1, "R5 mux to cas", cyc - ras_fall_cyc, T_MUX + 1);
      end
      if (!p_cas && cas_n) check(clo_run >= T_CAS, "R4 cas active", clo_run, T_CAS);
      if (!oe_n) oe_seen = 1'b1;
      if (pc_ras && !c_ras_n) begin c_ras_fall = cyc; c_fall_cas = c_cas_n; end
      if (pc_cas && !c_cas_n) c_cas_fall = cyc;
      if (!pc_ras && c_ras_n) c_ras_rise = cyc;
      if (!pc_cas && c_cas_n) c_cas_rise = cyc;
    end
    lo_run  = ras_n ? 0 : lo_run + 1;
    hi_run  = ras_n ? hi_run + 1 : 0;
    clo_run = cas_n ? 0 : clo_run + 1;
    p_ras = ras_n; p_cas = cas_n; pc_ras = c_ras_n; pc_cas = c_cas_n;
  end

  // refresh extension model
  int m_prev = 0, m_ext = 0;
  function automatic int rf_row(input int a);
    if (m_prev == 127 && a == 0) m_ext = (m_ext + 1) % (1 << EXT_W);
    m_prev = a;
    return (m_ext << 7) | a;
  endfunction

  task automatic bus_idle();
    mreq_n = 1; rd_n = 1; wr_n = 1; rfsh_n = 1;
  endtask

  task automatic t_reset();
    check(ras_n == 1, "R1 ras", ras_n, 1);
    check(cas_n == 1, "R1 cas", cas_n, 1);
    check(we_n == 1,  "R1 we",  we_n,  1);
    check(oe_n == 1,  "R1 oe",  oe_n,  1);
  endtask

  task automatic t_access(input logic [PAGE_W-1:0] pg, input logic [15:0] a,
                          input bit wr, input int hold);
    logic [PAGE_W+15:0] ph;
    int f0;
    ph = {pg, a};
    f0 = ras_falls;
    oe_seen = 0;
    @(negedge clk);
    page = pg; addr = a; mreq_n = 0;
    if (wr) wr_n = 0; else rd_n = 0;
    repeat (hold) @(negedge clk);
    if (hold > 1) check(ras_n == 0, "R8 ras held while mreq low", ras_n, 0);
    bus_idle();
    repeat (10) @(negedge clk);
    check(ras_n == 1, "R8 ras released", ras_n, 1);
    check(ras_falls == f0 + 1, "R8 one row cycle", ras_falls - f0, 1);
    check(ras_fall_addr == int'(ph[ROW_W-1:0]), "R5 row addr", ras_fall_addr, int'(ph[ROW_W-1:0]));
    check(cas_fall_addr == int'(ph[2*ROW_W-1:ROW_W]), "R5 col addr",
          cas_fall_addr, int'(ph[2*ROW_W-1:ROW_W]));
    check(cas_fall_we == !wr, "R6 we at cas", cas_fall_we, !wr);
    check(oe_seen == !wr, "R7 oe on read only", oe_seen, !wr);
    check(last_lo >= T_RAS, "R2 row pulse", last_lo, T_RAS);
  endtask

  task automatic t_refresh(input int a);
    int f0, c0, exp;
    f0 = ras_falls; c0 = cas_falls; oe_seen = 0;
    exp = rf_row(a);
    @(negedge clk);
    rf_a = 7'(a); mreq_n = 0; rfsh_n = 0;
    @(negedge clk);
    bus_idle();
    repeat (10) @(negedge clk);
    check(ras_falls == f0 + 1, "R9 refresh pulse", ras_falls - f0, 1);
    check(cas_falls == c0, "R9 cas idle in refresh", cas_falls - c0, 0);
    check(ras_fall_addr == exp, "R10 refresh row", ras_fall_addr, exp);
    check(oe_seen == 0, "R7 oe idle in refresh", oe_seen, 0);
    check(c_fall_cas == 0, "R11 cas low at ras fall", c_fall_cas, 0);
    check(c_ras_fall - c_cas_fall >= T_CSR, "R11 cas lead", c_ras_fall - c_cas_fall, T_CSR);
    check(c_ras_rise == c_cas_rise, "R11 joint rise", c_cas_rise, c_ras_rise);
  endtask

  task automatic t_refresh_mid_access();
    int f0, exp;
    f0 = ras_falls;
    @(negedge clk);
    page = 2'd1; addr = 16'h0f0f; mreq_n = 0; rd_n = 0;
    repeat (3) @(negedge clk);
    rf_a = 7'd42; rfsh_n = 0;
    exp = rf_row(42);
    @(negedge clk);
    rfsh_n = 1;
    repeat (6) @(negedge clk);
    check(ras_falls == f0 + 1, "R12 refresh deferred", ras_falls - f0, 1);
    check(ras_n == 0, "R12 access row kept", ras_n, 0);
    bus_idle();
    repeat (14) @(negedge clk);
    check(ras_falls == f0 + 2, "R12 refresh serviced", ras_falls - f0, 2);
    check(ras_fall_addr == exp, "R12 refresh row", ras_fall_addr, exp);
    check(last_hi >= T_RP, "R12 precharge before refresh", last_hi, T_RP);
    check(ras_fall_cas == 1, "R9 cas high at refresh", ras_fall_cas, 1);
  endtask

  initial begin
    rst_n = 0; bus_idle(); addr = '0; page = '0; rf_a = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_access(2'd2, 16'h1234, 1'b0, 6);
    t_access(2'd3, 16'hffff, 1'b0, 4);
    t_access(2'd1, 16'h4abc, 1'b1, 5);
    t_access(2'd0, 16'h8001, 1'b0, 1);
    t_access(2'd2, 16'h00ff, 1'b1, 1);
    t_refresh(21);
    t_refresh(127);
    t_refresh(0);
    for (int i = 0; i < 3; i++) begin
      t_refresh(127);
      t_refresh(0);
    end
    t_refresh(0);
    t_refresh_mid_access();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule